// File: doc/BRIEF.md
# Precision-Tagged Direct-Mapped Data Cache

This block is a small direct-mapped, write-back data cache that sits between a processor's load/store unit and a word-addressed memory. Each request from the processor carries a flag that marks it as precise or approximate. Each cache line keeps one precision bit next to its tag, valid bit and dirty bit. The precision bit comes from the access that filled the line. Software is expected to touch a given piece of data with one precision only. When an access does not agree with the line's bit, the cache returns pseudo-random garbage in place of the stored word. This models what happens when a low-voltage storage cell is read as if it were a full-voltage one.

When the injection input is high, loads that hit approximate lines have their low four bits disturbed. This models errors that build up in approximate storage. Garbage and disturbance both come from one 32-bit LFSR. Misses go to memory one word per handshake. A dirty victim is written back in full before the new line is fetched.

Top module: `approx_cache`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, `cpu_resp_valid` and `mem_req_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: The word address is split into three fields. Bits [1:0] select the word within a four-word line. Bits [5:2] select one of 16 lines. Bits [11:6] are the tag. Memory traffic for a line uses the addresses {tag, index, w} for w = 0..3.
- R3: A load hit accepted on one rising edge presents `cpu_resp_valid` with the data after that edge, that is one cycle later, and causes no memory request.
- R4: `cpu_req_ready` is 1 only while the controller is idle. It stays 0 from the edge that accepts a miss until the miss has been answered.
- R5: A miss on a line that is invalid or clean makes four memory reads of the new line, in ascending word order, and no writes. It then answers the original access.
- R6: A miss on a valid dirty line first writes back the four old words in ascending order, to the old tag's addresses, and then makes the four reads of R5.
- R7: A fill copies the request's precision flag (1 = approximate) into the line's bit and clears dirty. A store that misses is then applied to the filled line, which leaves it dirty.
- R8: A store hit writes only the addressed word and sets dirty. The line's precision bit is left unchanged.
- R9: An access whose flag differs from the line's bit is a mismatch. A mismatched load returns the current LFSR state. A mismatched store still writes its word. Each mismatch advances the LFSR once. The LFSR starts at 32'h00000001 and steps as s' = (s >> 1) ^ (s[0] ? 32'h80200003 : 0).
- R10: With `inject_en` high, a load whose flag and line bit are both approximate returns the stored word with bits [3:0] XORed with LFSR bits [3:0], and the LFSR advances once. Precise loads, and approximate loads with `inject_en` low, return the stored word exactly.
- R11: Every store is answered by one `cpu_resp_valid` pulse with `cpu_resp_rdata` equal to 0.
- R12: A memory request holds its valid, address, direction and write data until `mem_req_ready` is sampled high. Read data is taken from `mem_resp_rdata` on the edge where `mem_resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache is idle and accepts a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_approx | input | 1 | 1 = approximate access, 0 = precise |
| cpu_req_addr | input | 12 | Word address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | 32 | Load data, 0 for stores |
| inject_en | input | 1 | Enables bit disturbance on approximate loads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write one word, 0 = read one word |
| mem_req_addr | output | 12 | Memory word address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_rdata | input | 32 | Read data |

## Verification
A hit response is due exactly one cycle after the accepting edge. The bench drives each request on a falling edge and expects `cpu_resp_valid` at the very next falling edge. A miss takes a variable number of cycles because of random memory stalls. For a miss, the bench checks `cpu_req_ready` at every falling edge until the response arrives, then compares the data and the logged memory handshakes with values from its own model of tags, precision bits and the LFSR. The memory model samples each handshake on the falling edge before the accepting rising edge. It returns read data one cycle after acceptance, so the cache takes it on the edge that follows.

// File: rtl/approx_cache.sv
module approx_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  parameter logic [31:0] LFSR_TAPS = 32'h80200003,
  parameter logic [31:0] LFSR_SEED = 32'h00000001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic              cpu_req_approx,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  input  logic              inject_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_W = OFF_W'(WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FREQ, S_FWAIT, S_REPLAY} state_t;

  state_t state;
  logic [OFF_W-1:0]  wcnt;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_write_q, req_approx_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [31:0]       lfsr_q;

  logic [DATA_W-1:0] data_q  [LINES*WORDS];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINES-1:0]  valid_q, dirty_q, approx_q;

  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;

  wire               sel_port   = (state == S_IDLE);
  wire [ADDR_W-1:0]  acc_addr   = sel_port ? cpu_req_addr   : req_addr_q;
  wire               acc_write  = sel_port ? cpu_req_write  : req_write_q;
  wire               acc_approx = sel_port ? cpu_req_approx : req_approx_q;
  wire [DATA_W-1:0]  acc_wdata  = sel_port ? cpu_req_wdata  : req_wdata_q;
  wire               acc_go     = (sel_port && cpu_req_valid) || (state == S_REPLAY);

  wire [IDX_W-1:0]   acc_idx = acc_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0]   acc_off = acc_addr[OFF_W-1:0];
  wire [TAG_W-1:0]   acc_tag = acc_addr[ADDR_W-1 -: TAG_W];

  wire               hit      = valid_q[acc_idx] && (tag_q[acc_idx] == acc_tag);
  wire               acc_hit  = acc_go && hit;
  wire               mismatch = approx_q[acc_idx] != acc_approx;
  wire [DATA_W-1:0]  word     = data_q[{acc_idx, acc_off}];
  wire               inj      = acc_approx && !acc_write && inject_en && !mismatch;
  wire               lfsr_step = acc_hit && (mismatch || inj);

  wire [IDX_W-1:0]   v_idx        = req_addr_q[OFF_W +: IDX_W];
  wire               victim_dirty = valid_q[v_idx] && dirty_q[v_idx];
  wire               in_replay    = (state == S_REPLAY);

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    if (acc_write)     rd_val = '0;
    else if (mismatch) rd_val = DATA_W'(lfsr_q);
    else if (inj)      rd_val = word ^ {{(DATA_W-4){1'b0}}, lfsr_q[3:0]};
    else               rd_val = word;
  end

  assign cpu_req_ready  = sel_port;
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_rdata = resp_data_q;

  assign mem_req_valid = (state == S_WB) || (state == S_FREQ);
  assign mem_req_write = (state == S_WB);
  assign mem_req_addr  = (state == S_WB) ? {tag_q[v_idx], v_idx, wcnt}
                                         : {req_addr_q[ADDR_W-1:OFF_W], wcnt};
  assign mem_req_wdata = data_q[{v_idx, wcnt}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      wcnt         <= '0;
      req_addr_q   <= '0;
      req_write_q  <= 1'b0;
      req_approx_q <= 1'b0;
      req_wdata_q  <= '0;
      valid_q      <= '0;
      dirty_q      <= '0;
      approx_q     <= '0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
      lfsr_q       <= LFSR_SEED;
    end else begin
      resp_valid_q <= 1'b0;
      if (lfsr_step)
        lfsr_q <= {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? LFSR_TAPS : 32'h0);
      if (acc_hit) begin
        resp_valid_q <= 1'b1;
        resp_data_q  <= rd_val;
        if (acc_write) dirty_q[acc_idx] <= 1'b1;
      end
      case (state)
        S_IDLE: if (cpu_req_valid && !hit) begin
          req_addr_q   <= cpu_req_addr;
          req_write_q  <= cpu_req_write;
          req_approx_q <= cpu_req_approx;
          req_wdata_q  <= cpu_req_wdata;
          wcnt         <= '0;
          state        <= (valid_q[acc_idx] && dirty_q[acc_idx]) ? S_WB : S_FREQ;
        end
        S_WB: if (mem_req_ready) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == LAST_W) state <= S_FREQ;
        end
        S_FREQ: if (mem_req_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_resp_valid) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == LAST_W) begin
            tag_q[v_idx]    <= req_addr_q[ADDR_W-1 -: TAG_W];
            valid_q[v_idx]  <= 1'b1;
            dirty_q[v_idx]  <= 1'b0;
            approx_q[v_idx] <= req_approx_q;
            state           <= S_REPLAY;
          end else begin
            state <= S_FREQ;
          end
        end
        S_REPLAY: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acc_hit && acc_write)
      data_q[{acc_idx, acc_off}] <= acc_wdata;
    else if (state == S_FWAIT && mem_resp_valid)
      data_q[{v_idx, wcnt}] <= mem_resp_rdata;
  end
endmodule

// File: rtl/approx_cache_chk.sv
module approx_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              hit,
  input logic              victim_dirty,
  input logic              in_replay
);
  // R4
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && hit) |=> (cpu_resp_valid && !mem_req_valid));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R6
  wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> victim_dirty);

  // R5
  replay_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_replay |=> (cpu_resp_valid && cpu_req_ready));
endmodule

bind approx_cache approx_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_resp_valid(cpu_resp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .hit(hit), .victim_dirty(victim_dirty), .in_replay(in_replay)
);

// File: tb/approx_cache_tb.sv
module approx_cache_tb;
  logic        clk = 0, rst_n = 0;
  logic        cpu_req_valid = 0, cpu_req_write = 0, cpu_req_approx = 0;
  logic [11:0] cpu_req_addr = 0;
  logic [31:0] cpu_req_wdata = 0;
  logic        cpu_req_ready, cpu_resp_valid;
  logic [31:0] cpu_resp_rdata;
  logic        inject_en = 0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1;
  logic [11:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_resp_valid = 0;
  logic [31:0] mem_resp_rdata = 0;

  int checks = 0, errors = 0;
  bit stall_en = 0, done = 0;

  always #2 clk = ~clk;

  approx_cache u_dut (.*);

  logic [31:0] mem_m  [int];
  logic [31:0] arch_m [int];
  int          log_n;
  logic [11:0] log_addr [16];
  bit          log_wr   [16];
  bit          pend_rd = 0;
  logic [11:0] pend_addr;

  bit         mvalid [16], mdirty [16], mapprox [16];
  logic [5:0] mtag   [16];
  logic [31:0] lfsr = 32'h1;

  function automatic logic [31:0] init_word(int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] mread(int a);
    return mem_m.exists(a) ? mem_m[a] : init_word(a);
  endfunction
  function automatic logic [31:0] aread(int a);
    return arch_m.exists(a) ? arch_m[a] : init_word(a);
  endfunction
  function automatic logic [31:0] lfsr_next(logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_resp_valid = 0;
    if (pend_rd) begin
      mem_resp_valid = 1;
      mem_resp_rdata = mread(pend_addr);
      pend_rd = 0;
    end
    mem_req_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (log_n < 16) begin
        log_addr[log_n] = mem_req_addr;
        log_wr[log_n]   = mem_req_write;
      end
      log_n++;
      if (mem_req_write) mem_m[mem_req_addr] = mem_req_wdata;
      else begin pend_rd = 1; pend_addr = mem_req_addr; end
    end
  end

  task automatic access(bit wr, bit ap, logic [11:0] a, logic [31:0] wd);
    logic [3:0]  idx = a[5:2];
    logic [5:0]  tg  = a[11:6];
    bit          mhit = mvalid[idx] && mtag[idx] == tg;
    bit          evict = !mhit && mvalid[idx] && mdirty[idx];
    logic [11:0] e_addr [8];
    bit          e_wr [8];
    int          e_n = 0, lat;
    bit          busy_bad = 0, mism, inj;
    logic [31:0] exp;
    string       dreq;
    if (!mhit) begin
      if (evict)
        for (int w = 0; w < 4; w++) begin
          e_addr[e_n] = {mtag[idx], idx, 2'(w)}; e_wr[e_n] = 1; e_n++;
        end
      for (int w = 0; w < 4; w++) begin
        e_addr[e_n] = {tg, idx, 2'(w)}; e_wr[e_n] = 0; e_n++;
      end
      mtag[idx] = tg; mvalid[idx] = 1; mdirty[idx] = 0; mapprox[idx] = ap;  // R7
    end
    mism = mapprox[idx] != ap;
    inj  = ap && !wr && inject_en && !mism;
    if (wr) begin
      arch_m[a] = wd; mdirty[idx] = 1; exp = 0; dreq = "R11";
      if (mism) lfsr = lfsr_next(lfsr);
    end else if (mism) begin
      exp = lfsr; lfsr = lfsr_next(lfsr); dreq = "R9";
    end else begin
      exp = aread(a); dreq = mhit ? "R3" : "R7";
      if (inj) begin exp ^= {28'h0, lfsr[3:0]}; lfsr = lfsr_next(lfsr); dreq = "R10"; end
    end

    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    log_n = 0;
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_approx = ap;
    cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    lat = 1;
    while (!cpu_resp_valid && lat < 200) begin
      if (cpu_req_ready) busy_bad = 1;
      lat++;
      @(negedge clk);
    end
    chk(cpu_resp_valid, "R4", "response missing", 32'(lat), 32'd0);
    chk(cpu_resp_rdata === exp, dreq, "response data", cpu_resp_rdata, exp);
    if (mhit) chk(lat == 1, "R3", "hit latency", 32'(lat), 32'd1);
    else chk(!busy_bad, "R4", "ready while busy", 32'(busy_bad), 32'd0);
    chk(log_n == e_n, evict ? "R6" : (mhit ? "R3" : "R5"), "handshake count",
        32'(log_n), 32'(e_n));
    for (int k = 0; k < e_n && k < log_n; k++)
      chk(log_addr[k] == e_addr[k] && log_wr[k] == e_wr[k], evict ? "R6" : "R2",
          "handshake addr/dir", {19'h0, log_wr[k], log_addr[k]}, {19'h0, e_wr[k], e_addr[k]});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R4: watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin mvalid[i] = 0; mdirty[i] = 0; mapprox[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset outputs
    chk(cpu_req_ready == 1, "R1", "ready after reset", 32'(cpu_req_ready), 1);
    chk(cpu_resp_valid == 0, "R1", "resp after reset", 32'(cpu_resp_valid), 0);
    chk(mem_req_valid == 0, "R1", "mem req after reset", 32'(mem_req_valid), 0);

    access(0, 0, 12'h040, 0);            // R1/R5 cold miss, R2 fields
    access(0, 0, 12'h043, 0);            // R3 hit
    access(1, 0, 12'h041, 32'hCAFEF00D); // R8 store hit
    access(0, 0, 12'h041, 0);            // R8 read back
    access(0, 1, 12'h042, 0);            // R9 mismatched load
    access(1, 1, 12'h040, 32'h11112222); // R9 mismatched store writes
    access(0, 0, 12'h040, 0);            // precision still precise
    access(1, 1, 12'h0C6, 32'hABCD0123); // R7 store miss, approximate
    access(0, 0, 12'h0C5, 0);            // R9 precise on approx line
    access(0, 0, 12'h080, 0);            // R6 dirty evict of line 0
    access(0, 1, 12'h0C6, 0);            // R10 inject off: exact
    inject_en = 1;
    access(0, 1, 12'h0C6, 0);            // R10 injected
    access(0, 0, 12'h083, 0);            // R10 precise unaffected
    access(0, 1, 12'h1C4, 0);            // R6 evict dirty approx line
    inject_en = 0;

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      stall_en  = (n >= 200);
      inject_en = ($urandom % 3 == 0);
      a = {4'h0, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom)};
      access($urandom % 2, ($urandom % 4 == 0), a, $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule